// File: doc/BRIEF.md
# Condition-Field Mask-Match Execution Unit

This execution unit carries out a family of six condition-field operations for a 64-bit core that keeps eight 4-bit condition fields. Each operation takes a 4-bit source nibble, which is either a condition field or a few bits of an integer operand. It compares every source bit with a pattern bit. The comparison counts only where a select mask allows it, and the result is a vector of match terms.

Depending on the operation, the match terms are handled in one of three ways:
- They are folded into one bit (any or all) or passed on as four bits to an integer destination.
- They are written into a whole condition field. A merge flag keeps or clears the bits outside the mask.
- They set one condition bit.

A field-to-field copy variant XORs the pattern onto the masked copy. Software can therefore copy, invert, set or clear individual bits with one datapath.

The unit holds the condition fields itself and exposes them as a flat vector. An integer-destination operation can also update field 0 with a sign summary of its result. All state changes, and the registered integer result, take effect on the clock edge on which `valid_i` is high.

Top module: `cfmatch_unit`

## Requirements
- R1: An instruction word is accepted only when bits 31:26 equal 19 and bits 5:1 equal 00011. Any other word leaves every output and every field unchanged. The field layout is as follows:
  - register/destination index D is bits 25:21
  - merge flag M is bit 20
  - select mask is bits 19:16
  - field selector F is bits 15:13
  - group is bits 12:11
  - reserved flag is bit 10
  - pattern is bits 9:6
  - variant bit V is bit 0
- R2: Match term i (i = 0..3) is set when mask bit i is 1 and pattern bit i equals source bit i. Group 00 reduces the terms of field F: with M=1 the result is 1 if any term is set, and with M=0 it is 1 only if the term vector equals the mask. The result goes to `res_o` bit 0, with all other bits zero and `res_idx_o`=D.
- R3: Group 01 writes the four match terms of field F into `res_o[3:0]`, with all other bits zero and `res_idx_o`=D.
- R4: In groups 00 and 01 with V=1, field 0 receives a summary of the 64-bit result taken as signed: bit 3 is set when the result is below zero, bit 2 when it is above zero, and bit 1 when it equals zero. Bit 0 copies `ov_sticky_i`. With V=0 no field changes.
- R5: Group 10 with V=0 writes field F from match terms whose source bit i is operand bit i. When D=0 the operand is zero regardless of `opa_i`.
- R6: Group 10 with V=1 compares all four bits against operand bit 0 only.
- R7: In group 10, field bits whose mask bit is 0 keep their old value when M=1 and are cleared when M=0.
- R8: Group 11 with V=1 writes field D[2:0] with ((mask AND field F) OR (M ? old AND NOT mask : 0)) XOR pattern.
- R9: Group 11 with V=0 writes the any/all reduction of field F's terms into bit D[4:3] of field D[2:0]. No other bit changes.
- R10: An accepted word with the reserved flag set raises `illegal_o` in the following cycle and writes nothing.
- R11: After reset all fields read zero, and `res_valid_o` and `illegal_o` are low.
- R12: Results appear on the edge that samples `valid_i`:
  - `res_valid_o`, `res_o`, `res_idx_o` and `illegal_o` are registered;
  - field bit i of field f is `cr_o[4*f+i]`;
  - `res_valid_o` is high for one cycle per integer-destination operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 64 | Contents of integer register D |
| ov_sticky_i | input | 1 | Sticky overflow copied into the field-0 summary |
| res_valid_o | output | 1 | Integer result valid (registered) |
| res_idx_o | output | 5 | Integer destination index |
| res_o | output | 64 | Integer result |
| illegal_o | output | 1 | Reserved encoding seen in the previous cycle |
| cr_o | output | 32 | All condition fields, field f at bits 4f+3..4f |

## Verification
The bench builds the unit with its default parameters: a 64-bit operand, eight fields and 4-bit fields. With these values the whole encoding space is reachable, including the 3-bit field selector and the 2-bit bit selector of the single-bit write. Field contents are first loaded through the move-from-integer group. Later copy, merge and single-bit operations then run against known non-trivial old values, so the preserved bits can be checked against expected values.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
   localparam logic [5:0] PRI_OPC = 6'd19;
   localparam logic [4:0] EXT_OPC = 5'b00011;

   typedef enum logic [1:0] {
      GRP_TOINT  = 2'b00,
      GRP_TOINT4 = 2'b01,
      GRP_FROMINT = 2'b10,
      GRP_CRCR   = 2'b11
   } grp_e;

   typedef struct packed {
      logic       ours;
      logic       rsvd;
      logic [4:0] dreg;
      logic       mflag;
      logic [3:0] msk;
      logic [2:0] fsel;
      grp_e       grp;
      logic [3:0] pat;
      logic       vbit;
   } dec_t;
endpackage

// File: rtl/cfm_decode.sv
module cfm_decode
   import cfm_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        dec
);
   always_comb begin
      dec.ours  = (insn[31:26] == PRI_OPC) && (insn[5:1] == EXT_OPC);
      dec.dreg  = insn[25:21];
      dec.mflag = insn[20];
      dec.msk   = insn[19:16];
      dec.fsel  = insn[15:13];
      dec.grp   = grp_e'(insn[12:11]);
      dec.rsvd  = insn[10];
      dec.pat   = insn[9:6];
      dec.vbit  = insn[0];
   end
endmodule

// File: rtl/cfm_match.sv
module cfm_match #(
   parameter int FW = 4
) (
   input  logic [FW-1:0] src,
   input  logic [FW-1:0] pat,
   input  logic [FW-1:0] msk,
   input  logic          any_mode,
   output logic [FW-1:0] terms,
   output logic          red
);
   for (genvar i = 0; i < FW; i++) begin : g_term
      assign terms[i] = msk[i] & (pat[i] == src[i]);
   end

   assign red = any_mode ? (|terms) : (terms == msk);
endmodule

// File: rtl/cfm_crfile.sv
module cfm_crfile #(
   parameter int              NFIELD = 8,
   parameter int              FW     = 4,
   parameter logic [FW-1:0]   RST_VAL = '0,
   localparam int             IDXW   = $clog2(NFIELD)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [IDXW-1:0]      widx,
   input  logic [FW-1:0]        wdata,
   output logic [NFIELD*FW-1:0] cr_flat
);
   for (genvar f = 0; f < NFIELD; f++) begin : g_fld
      logic [FW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                     q <= RST_VAL;
         else if (we && widx == IDXW'(f)) q <= wdata;
      end
      assign cr_flat[f*FW +: FW] = q;
   end

   // R1
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cr_flat));
endmodule

// File: rtl/cfmatch_unit.sv
module cfmatch_unit
   import cfm_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int NFIELD = 8,
   parameter int FW     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic [31:0]          insn_i,
   input  logic [XLEN-1:0]      opa_i,
   input  logic                 ov_sticky_i,
   output logic                 res_valid_o,
   output logic [4:0]           res_idx_o,
   output logic [XLEN-1:0]      res_o,
   output logic                 illegal_o,
   output logic [NFIELD*FW-1:0] cr_o
);
   localparam int IDXW = $clog2(NFIELD);
   localparam int CRW  = NFIELD * FW;

   if (FW != 4) begin : g_bad_fw
      $error("cfmatch_unit: field width must be 4");
   end
   if (NFIELD != 8) begin : g_bad_nf
      $error("cfmatch_unit: encoding addresses exactly 8 fields");
   end
   if (XLEN < 2 * FW) begin : g_bad_xlen
      $error("cfmatch_unit: operand too narrow");
   end

   dec_t d;
   cfm_decode u_dec (.insn(insn_i), .dec(d));

   logic act;
   assign act = valid_i && d.ours && !d.rsvd;

   // source selection
   logic [FW-1:0] fld_src, int_src, m_src;
   logic [XLEN-1:0] opnd;
   logic unused_opa_hi;
   assign opnd          = (d.dreg == 5'd0) ? '0 : opa_i;
   assign unused_opa_hi = ^opnd[XLEN-1:FW];
   assign fld_src       = cr_o[FW*int'(d.fsel) +: FW];
   assign int_src       = d.vbit ? {FW{opnd[0]}} : opnd[FW-1:0];
   assign m_src         = (d.grp == GRP_FROMINT) ? int_src : fld_src;

   logic [FW-1:0] terms;
   logic          red;
   cfm_match #(.FW(FW)) u_match (
      .src(m_src), .pat(d.pat), .msk(d.msk), .any_mode(d.mflag),
      .terms(terms), .red(red)
   );

   // destination field and old contents
   logic [IDXW-1:0] dst_idx;
   logic [FW-1:0]   old_dst, keep_bits;
   always_comb begin
      unique case (d.grp)
         GRP_FROMINT: dst_idx = d.fsel;
         GRP_CRCR:    dst_idx = d.dreg[2:0];
         default:     dst_idx = '0;
      endcase
   end
   assign old_dst   = cr_o[FW*int'(dst_idx) +: FW];
   assign keep_bits = d.mflag ? (old_dst & ~d.msk) : '0;

   // integer result and sign summary
   logic [XLEN-1:0] ires;
   logic            s_lt, s_eq, s_gt;
   assign ires = (d.grp == GRP_TOINT) ? {{(XLEN-1){1'b0}}, red}
                                      : {{(XLEN-FW){1'b0}}, terms};
   assign s_lt = ires[XLEN-1];
   assign s_eq = (ires == '0);
   assign s_gt = !s_lt && !s_eq;

   // new field contents
   logic [FW-1:0] wnib;
   logic          cr_we;
   always_comb begin
      wnib = old_dst;
      unique case (d.grp)
         GRP_FROMINT: wnib = terms | keep_bits;
         GRP_CRCR: begin
            if (d.vbit) wnib = ((d.msk & fld_src) | keep_bits) ^ d.pat;
            else        wnib[d.dreg[4:3]] = red;
         end
         default:     wnib = {s_lt, s_gt, s_eq, ov_sticky_i};
      endcase
   end
   assign cr_we = act && (d.grp[1] || d.vbit);

   cfm_crfile #(.NFIELD(NFIELD), .FW(FW)) u_cr (
      .clk(clk), .rst_n(rst_n), .we(cr_we), .widx(dst_idx),
      .wdata(wnib), .cr_flat(cr_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         res_idx_o   <= '0;
         res_o       <= '0;
         illegal_o   <= 1'b0;
      end else begin
         res_valid_o <= act && !d.grp[1];
         illegal_o   <= valid_i && d.ours && d.rsvd;
         if (act && !d.grp[1]) begin
            res_idx_o <= d.dreg;
            res_o     <= ires;
         end
      end
   end

   logic [CRW-1:0] wmask;
   assign wmask = CRW'(d.msk) << (FW * int'(d.fsel));

   // R10
   rsvd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> $stable(cr_o) && !res_valid_o);
   // R2
   int_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> res_o[XLEN-1:FW] == '0);
   // R9
   single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && d.grp == GRP_CRCR && !d.vbit) |=> $countones(cr_o ^ $past(cr_o)) <= 1);
   // R4
   no_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !d.grp[1] && !d.vbit) |=> $stable(cr_o));
   // R7
   merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && d.grp == GRP_FROMINT && d.mflag) |=>
         ((cr_o ^ $past(cr_o)) & ~$past(wmask)) == '0);
endmodule

// File: tb/cfmatch_unit_tb.sv
module cfmatch_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic [63:0] opa_i = '0;
   logic        ov_sticky_i = 1'b0;
   logic        res_valid_o;
   logic [4:0]  res_idx_o;
   logic [63:0] res_o;
   logic        illegal_o;
   logic [31:0] cr_o;

   always #4 clk = ~clk;   // 125 MHz

   cfmatch_unit u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
      .opa_i(opa_i), .ov_sticky_i(ov_sticky_i), .res_valid_o(res_valid_o),
      .res_idx_o(res_idx_o), .res_o(res_o), .illegal_o(illegal_o), .cr_o(cr_o)
   );

   typedef struct {
      int          req;
      logic [31:0] cr;
      logic        rv;
      logic [4:0]  idx;
      logic [63:0] res;
      logic        ill;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] m_cr = '0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   function automatic logic [31:0] enc(input int op, input logic [4:0] dr,
         input logic m, input logic [3:0] msk, input logic [2:0] f,
         input logic [1:0] grp, input logic rs, input logic [3:0] pat,
         input logic v);
      logic [31:0] w;
      w = {op[5:0], dr, m, msk, f, grp, rs, pat, 5'b00011, v};
      return w;
   endfunction

   function automatic logic [3:0] mterms(input logic [3:0] s, input logic [3:0] p,
                                         input logic [3:0] k);
      logic [3:0] t;
      for (int i = 0; i < 4; i++) t[i] = k[i] & (p[i] == s[i]);
      return t;
   endfunction

   task automatic issue(input int req, input logic [31:0] w,
                        input logic [63:0] a, input logic ov);
      exp_t e;
      logic [5:0] op; logic [4:0] dr; logic m; logic [3:0] k, p, t, src, old, nv;
      logic [2:0] f, dst; logic [1:0] g; logic rs, v, ours, r; logic [63:0] aa;
      op = w[31:26]; dr = w[25:21]; m = w[20]; k = w[19:16]; f = w[15:13];
      g = w[12:11]; rs = w[10]; p = w[9:6]; v = w[0];
      ours = (op == 6'd19) && (w[5:1] == 5'b00011);
      aa = (dr == 0) ? 64'd0 : a;
      e.req = req; e.rv = 0; e.idx = 'x; e.res = 'x; e.ill = ours && rs;
      if (ours && !rs) begin
         if (g == 2'b10) src = v ? {4{aa[0]}} : aa[3:0];
         else            src = m_cr[4*f +: 4];
         t = mterms(src, p, k);
         r = m ? (|t) : (t == k);
         case (g)
            2'b00, 2'b01: begin
               e.rv = 1; e.idx = dr;
               e.res = (g == 2'b00) ? {63'd0, r} : {60'd0, t};
               if (v) m_cr[3:0] = {1'b0, e.res != 0, e.res == 0, ov};
            end
            2'b10: begin
               old = m_cr[4*f +: 4];
               m_cr[4*f +: 4] = t | (m ? (old & ~k) : 4'd0);
            end
            default: begin
               dst = dr[2:0]; old = m_cr[4*dst +: 4];
               if (v) nv = ((k & src) | (m ? (old & ~k) : 4'd0)) ^ p;
               else begin nv = old; nv[dr[4:3]] = r; end
               m_cr[4*dst +: 4] = nv;
            end
         endcase
      end
      e.cr = m_cr;
      @(negedge clk);
      valid_i = 1; insn_i = w; opa_i = a; ov_sticky_i = ov;
      sb.push_back(e);
      @(negedge clk);
      valid_i = 0;
   endtask

   // monitor: each pushed item belongs to the following rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk); #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (cr_o !== e.cr || res_valid_o !== e.rv || illegal_o !== e.ill ||
                (e.rv && (res_o !== e.res || res_idx_o !== e.idx))) begin
               errors++;
               $display("FAIL R%0d: cr=%h rv=%b ill=%b res=%h idx=%0d exp cr=%h rv=%b ill=%b res=%h idx=%0d",
                        e.req, cr_o, res_valid_o, illegal_o, res_o, res_idx_o,
                        e.cr, e.rv, e.ill, e.res, e.idx);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      checks++;
      if (cr_o !== 32'd0 || res_valid_o !== 1'b0 || illegal_o !== 1'b0) begin
         errors++;
         $display("FAIL R11: cr=%h rv=%b ill=%b exp 0 0 0", cr_o, res_valid_o, illegal_o);
      end
      // R5 per-bit load of field 2 with 0xA
      issue(5, enc(19, 5'd1, 0, 4'hF, 3'd2, 2'b10, 0, 4'hF, 0), 64'h0A, 0);
      // R6 broadcast of operand bit 0 into field 3
      issue(6, enc(19, 5'd2, 0, 4'hF, 3'd3, 2'b10, 0, 4'b0101, 1), 64'hFFFF_0001, 0);
      // R5 index 0 forces zero operand
      issue(5, enc(19, 5'd0, 0, 4'hF, 3'd4, 2'b10, 0, 4'h0, 0), 64'hF, 0);
      // R7 merge keeps bits outside mask
      issue(7, enc(19, 5'd1, 1, 4'b0011, 3'd2, 2'b10, 0, 4'h0, 0), 64'h0, 0);
      // R7 without merge clears bits outside mask
      issue(7, enc(19, 5'd1, 0, 4'b0011, 3'd3, 2'b10, 0, 4'h0, 0), 64'h0, 0);
      // R2 all-reduction and any-reduction, no record
      issue(2, enc(19, 5'd7, 0, 4'b1011, 3'd2, 2'b00, 0, 4'b1011, 0), 64'h0, 0);
      issue(2, enc(19, 5'd8, 1, 4'b1100, 3'd2, 2'b00, 0, 4'b0100, 0), 64'h0, 0);
      issue(2, enc(19, 5'd9, 0, 4'b1111, 3'd2, 2'b00, 0, 4'b0000, 0), 64'h0, 0);
      // R4 record with sticky overflow
      issue(4, enc(19, 5'd3, 1, 4'b0001, 3'd2, 2'b00, 0, 4'b0001, 1), 64'h0, 1);
      // R3 four-bit result, with and without record; zero result sets EQ
      issue(3, enc(19, 5'd4, 0, 4'b1111, 3'd4, 2'b01, 0, 4'b1010, 0), 64'h0, 0);
      issue(4, enc(19, 5'd5, 0, 4'b0000, 3'd4, 2'b01, 0, 4'b1010, 1), 64'h0, 0);
      // R8 field copy with merge and with clear, pattern inverts
      issue(8, enc(19, 5'd5, 1, 4'b0110, 3'd2, 2'b11, 0, 4'b0100, 1), 64'h0, 0);
      issue(8, enc(19, 5'd6, 0, 4'b1001, 3'd2, 2'b11, 0, 4'b0001, 1), 64'h0, 0);
      // R9 single bit 2 of field 6, then bit 0 of field 7
      issue(9, enc(19, {2'b10, 3'd6}, 1, 4'b1000, 3'd2, 2'b11, 0, 4'b0000, 0), 64'h0, 0);
      issue(9, enc(19, {2'b00, 3'd7}, 0, 4'b1011, 3'd2, 2'b11, 0, 4'b1011, 0), 64'h0, 0);
      // R10 reserved pattern slot
      issue(10, enc(19, 5'd1, 0, 4'hF, 3'd1, 2'b10, 1, 4'hF, 0), 64'hF, 0);
      // R1 foreign opcode and foreign extended opcode ignored
      issue(1, enc(18, 5'd1, 0, 4'hF, 3'd1, 2'b10, 0, 4'hF, 0), 64'hF, 0);
      issue(1, enc(19, 5'd1, 0, 4'hF, 3'd1, 2'b10, 0, 4'hF, 0) ^ 32'h2, 64'hF, 0);
      // R12 back-to-back style: result valid only one cycle
      issue(12, enc(19, 5'd10, 1, 4'hF, 3'd3, 2'b01, 0, 4'h3, 0), 64'h0, 0);
      @(negedge clk);
      checks++;
      if (res_valid_o !== 1'b0) begin
         errors++;
         $display("FAIL R12: rv=%b exp 0", res_valid_o);
      end
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule